// File: doc/BRIEF.md
# Power-Loss Flags and Restart Policy

This block records the power-loss events seen by the platform and decides, each time main power-good returns, which sleep state the system resumes in. It watches the asynchronous main power-good and processor-regulator power-good levels, follows the resume-well reset to tell a brief power-good dip from a full outage, and latches the sleep state that was current at the moment power was lost.

Software reaches the block through a small register port. A 16-bit status word carries the power-good and processor-regulator failure flags. An 8-bit RTC-well configuration word carries the after-power-loss enable, the battery failure flag and the RTC power status. Reads are combinational. Writes take effect at the next clock edge.

A power-good dip during which the resume-well reset never asserts always ends in a reboot to S0. A full outage resumes as the enable selects: S0 when it is clear, otherwise S5, or S4 when the system was in S4 at the time power was lost.

Top module: `pwr_loss_policy`

## Requirements
- R1: While `rtc_rst_n` is low and after it rises, the status word reads 0x0000 and the configuration word reads 0x0004 (only the RTC power status set), and `restore_valid` is 0.
- R2: Status bit 0 (power-good failure) sets when synchronized main power-good falls while `sleep_state` is S0 (code 0) or S1 (code 1); a fall in any other state leaves it clear.
- R3: Status bit 0 clears when the status word is written with bit 0 at 1, or while `sleep_state` is G3 (code 7); writing 0 to it has no effect.
- R4: Status bit 1 (processor regulator failure) sets on a falling edge of synchronized regulator power-good and clears only when the status word is written with bit 1 at 1.
- R5: When main power-good falls and rises again while the resume-well reset stays high, `restore_valid` pulses for one cycle with `restore_state` S0 and `reboot_req` 1, whatever the enable holds.
- R6: When the resume-well reset is seen low at any time between the fall and the rise of main power-good, the event is a full outage; with the enable at 0 the outcome is S0 with `reboot_req` 1.
- R7: On a full outage with the enable at 1, the outcome is S5 (code 5) with `reboot_req` 0, except that S4 (code 4) is chosen when `sleep_state` was S4 at the moment power-good fell.
- R8: Configuration bit 1 (battery failure) is set in every cycle `trickle_fail` is high. It is cleared only by a configuration write with bit 1 at 1 or by `rtc_rst_n`. The resume-well reset and `sys_reset_wr` leave it unchanged.
- R9: Configuration bit 0 (after-power-loss enable) takes bit 0 of each configuration write. It is cleared by `sys_reset_wr`, which wins over a simultaneous write, or by `rtc_rst_n`. The resume-well reset leaves it unchanged.
- R10: Configuration bit 2 (RTC power status) is set while `rtc_rst_n` is low. A configuration write with bit 2 at 0 clears it; a write with bit 2 at 1 leaves it unchanged.
- R11: `rd_sel` 0 returns the status word and 1 returns the configuration word zero-extended to 16 bits; status bits 15:2 and configuration bits 7:3 always read 0.
- R12: A set event wins over a software clear in the same cycle, and each falling edge sets its flag at most once, so a flag cleared while its input stays low stays clear.
- R13: A change on an asynchronous input is acted on at the third rising clock edge after it (two synchronizer stages plus the edge register). Register writes and `trickle_fail` act at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rtc_rst_n | input | 1 | RTC-well reset, active low, asynchronous |
| rsm_rst_n | input | 1 | Resume-well reset, active low, asynchronous level |
| pwr_good_a | input | 1 | Main power-good, asynchronous |
| vreg_good_a | input | 1 | Processor regulator power-good, asynchronous |
| trickle_fail | input | 1 | Battery or trickle supply failure indication, synchronous |
| sleep_state | input | 3 | Current state: 0 S0, 1 S1, 3 S3, 4 S4, 5 S5, 7 G3 |
| sys_reset_wr | input | 1 | One-cycle pulse for a write to the system reset-control port |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status word, 1 configuration word |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read select: 0 status word, 1 configuration word |
| rd_data | output | 16 | Read data |
| restore_valid | output | 1 | One-cycle pulse when power-good returns after a recorded loss |
| restore_state | output | 3 | Target state of the last restore, held between restores |
| reboot_req | output | 1 | Reboot request, valid with `restore_valid` |

## Verification
Every asynchronous input is driven at a falling clock edge. Its effect on a flag or on the restore outputs is due at the third rising edge after that, so the checks sample at the falling edge that follows the third rising edge. The `restore_valid` pulse is then checked high once and low one cycle later. Register writes and `trickle_fail` are due at the very next rising edge and are read back at the falling edge after it. For the set-versus-clear race, the write is placed on exactly the edge where the detected falling edge is acted on.

// File: rtl/pwr_loss_policy.sv
module pwr_loss_policy #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rtc_rst_n,
  input  logic        rsm_rst_n,
  input  logic        pwr_good_a,
  input  logic        vreg_good_a,
  input  logic        trickle_fail,
  input  logic [2:0]  sleep_state,
  input  logic        sys_reset_wr,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        rd_sel,
  output logic [15:0] rd_data,
  output logic        restore_valid,
  output logic [2:0]  restore_state,
  output logic        reboot_req
);
  localparam logic [2:0] ST_S0 = 3'd0;
  localparam logic [2:0] ST_S1 = 3'd1;
  localparam logic [2:0] ST_S4 = 3'd4;
  localparam logic [2:0] ST_S5 = 3'd5;
  localparam logic [2:0] ST_G3 = 3'd7;
  localparam int         TOP   = SYNC_STAGES - 1;

  logic [TOP:0] pg_sync, vr_sync, rs_sync;
  logic         pg_prev, vr_prev;
  logic         pwrok_flr, cpu_flr, batt_flr, rtc_sts, resume_en;
  logic         lost, full;
  logic [2:0]   lost_state;

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      pg_sync <= '1;
      vr_sync <= '1;
      rs_sync <= '1;
      pg_prev <= 1'b1;
      vr_prev <= 1'b1;
    end else begin
      pg_sync <= {pg_sync[TOP-1:0], pwr_good_a};
      vr_sync <= {vr_sync[TOP-1:0], vreg_good_a};
      rs_sync <= {rs_sync[TOP-1:0], rsm_rst_n};
      pg_prev <= pg_sync[TOP];
      vr_prev <= vr_sync[TOP];
    end
  end

  wire pg_fall  = pg_prev & ~pg_sync[TOP];
  wire pg_rise  = ~pg_prev & pg_sync[TOP];
  wire vr_fall  = vr_prev & ~vr_sync[TOP];
  wire rs_low   = ~rs_sync[TOP];
  wire st_wr    = wr_en & ~wr_sel;
  wire cf_wr    = wr_en & wr_sel;
  wire in_s0s1  = (sleep_state == ST_S0) || (sleep_state == ST_S1);
  wire full_now = full | rs_low;

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      pwrok_flr <= 1'b0;
      cpu_flr   <= 1'b0;
      batt_flr  <= 1'b0;
      rtc_sts   <= 1'b1;
      resume_en <= 1'b0;
    end else begin
      if (pg_fall && in_s0s1)                              pwrok_flr <= 1'b1;
      else if ((st_wr && wr_data[0]) || sleep_state == ST_G3) pwrok_flr <= 1'b0;

      if (vr_fall)                  cpu_flr <= 1'b1;
      else if (st_wr && wr_data[1]) cpu_flr <= 1'b0;

      if (trickle_fail)             batt_flr <= 1'b1;
      else if (cf_wr && wr_data[1]) batt_flr <= 1'b0;

      if (cf_wr && !wr_data[2]) rtc_sts <= 1'b0;

      if (sys_reset_wr) resume_en <= 1'b0;
      else if (cf_wr)   resume_en <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      lost          <= 1'b0;
      full          <= 1'b0;
      lost_state    <= ST_S0;
      restore_valid <= 1'b0;
      restore_state <= ST_S0;
      reboot_req    <= 1'b0;
    end else begin
      restore_valid <= 1'b0;
      reboot_req    <= 1'b0;
      if (pg_fall) begin
        lost       <= 1'b1;
        full       <= rs_low;
        lost_state <= sleep_state;
      end else if (lost && pg_rise) begin
        lost          <= 1'b0;
        full          <= 1'b0;
        restore_valid <= 1'b1;
        if (full_now && resume_en) begin
          restore_state <= (lost_state == ST_S4) ? ST_S4 : ST_S5;
          reboot_req    <= 1'b0;
        end else begin
          restore_state <= ST_S0;
          reboot_req    <= 1'b1;
        end
      end else if (lost && rs_low) begin
        full <= 1'b1;
      end
    end
  end

  assign rd_data = rd_sel ? {13'd0, rtc_sts, batt_flr, resume_en}
                          : {14'd0, cpu_flr, pwrok_flr};

  assert_pwrok_set_R2: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    (pg_fall && in_s0s1) |=> pwrok_flr);

  assert_cpu_set_R4: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    vr_fall |=> cpu_flr);

  assert_glitch_reboot_R5: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    (lost && pg_rise && !full && !rs_low) |=> (restore_valid && reboot_req && restore_state == ST_S0));

  assert_full_s4_R7: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    (lost && pg_rise && full && resume_en && lost_state == ST_S4) |=> (restore_state == ST_S4 && !reboot_req));

  assert_batt_hold_R8: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    (batt_flr && !(cf_wr && wr_data[1])) |=> batt_flr);

  assert_en_clear_R9: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    sys_reset_wr |=> !rd_data[0] || !rd_sel);

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    rd_data[15:3] == 13'd0);

  assert_pulse_R13: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    restore_valid |=> !restore_valid);
endmodule

// File: tb/pwr_loss_policy_bench.sv
module pwr_loss_policy_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rtc_rst_n = 1'b0, rsm_rst_n = 1'b1;
  logic        pwr_good_a = 1'b1, vreg_good_a = 1'b1, trickle_fail = 1'b0;
  logic [2:0]  sleep_state = 3'd0;
  logic        sys_reset_wr = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        restore_valid, reboot_req;
  logic [2:0]  restore_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_loss_policy u_pwr_loss_policy (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .rsm_rst_n(rsm_rst_n),
    .pwr_good_a(pwr_good_a), .vreg_good_a(vreg_good_a), .trickle_fail(trickle_fail),
    .sleep_state(sleep_state), .sys_reset_wr(sys_reset_wr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .restore_valid(restore_valid), .restore_state(restore_state), .reboot_req(reboot_req));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    step(2);
    rd(0, v); check("R1 status in reset", v, 16'h0000);
    rd(1, v); check("R1 cfg in reset", v, 16'h0004);
    rtc_rst_n = 1'b1;
    step(2);
    rd(0, v); check("R1 status after reset", v, 16'h0000);
    rd(1, v); check("R1 cfg after reset", v, 16'h0004);
    check("R1 restore_valid", {15'd0, restore_valid}, 16'h0000);
  endtask

  task automatic t_cfg_bits();
    logic [15:0] v;
    wr(1, 16'hFFFC);
    rd(1, v); check("R10 write 1 keeps rtc status R11 reserved", v, 16'h0004);
    wr(1, 16'h0001);
    rd(1, v); check("R10 write 0 clears, R9 enable set", v, 16'h0001);
    sys_reset_wr = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0001;
    step(1);
    sys_reset_wr = 1'b0; wr_en = 1'b0;
    rd(1, v); check("R9 sys reset wins over write", v, 16'h0000);
    wr(1, 16'h0001);
    rsm_rst_n = 1'b0; step(4); rsm_rst_n = 1'b1; step(4);
    rd(1, v); check("R9 resume reset keeps enable", v, 16'h0001);
  endtask

  task automatic t_batt();
    logic [15:0] v;
    trickle_fail = 1'b1; step(1); trickle_fail = 1'b0;
    rd(1, v); check("R8 battery flag set", v, 16'h0003);
    rsm_rst_n = 1'b0; step(4); rsm_rst_n = 1'b1; step(4);
    sys_reset_wr = 1'b1; step(1); sys_reset_wr = 1'b0;
    rd(1, v); check("R8 battery kept, R9 enable cleared", v, 16'h0002);
    wr(1, 16'h0002);
    rd(1, v); check("R8 write 1 clears battery", v, 16'h0000);
  endtask

  task automatic t_glitch();
    logic [15:0] v;
    wr(1, 16'h0001);
    sleep_state = 3'd0; pwr_good_a = 1'b0;
    step(2);
    rd(0, v); check("R13 flag not early", v, 16'h0000);
    step(1);
    rd(0, v); check("R2 flag set at third edge", v, 16'h0001);
    pwr_good_a = 1'b1;
    step(3);
    check("R5 glitch valid", {15'd0, restore_valid}, 16'h0001);
    check("R5 glitch state S0", {13'd0, restore_state}, 16'h0000);
    check("R5 glitch reboot despite enable", {15'd0, reboot_req}, 16'h0001);
    step(1);
    check("R13 single pulse", {15'd0, restore_valid}, 16'h0000);
    wr(0, 16'h0000);
    rd(0, v); check("R3 write 0 no effect", v, 16'h0001);
    wr(0, 16'h0001);
    rd(0, v); check("R3 write 1 clears", v, 16'h0000);
  endtask

  task automatic t_full(input logic en, input logic [2:0] st, input logic [2:0] exp_st,
                        input logic exp_rb, input logic [15:0] exp_flag, input string req);
    logic [15:0] v;
    wr(1, {15'd0, en});
    sleep_state = st; pwr_good_a = 1'b0;
    step(3);
    rd(0, v); check({req, " R2 flag by state"}, v, exp_flag);
    rsm_rst_n = 1'b0; step(4); rsm_rst_n = 1'b1; step(2);
    pwr_good_a = 1'b1;
    step(3);
    check({req, " valid"}, {15'd0, restore_valid}, 16'h0001);
    check({req, " state"}, {13'd0, restore_state}, {13'd0, exp_st});
    check({req, " reboot"}, {15'd0, reboot_req}, {15'd0, exp_rb});
    sleep_state = 3'd0;
    wr(0, 16'h0003);
  endtask

  task automatic t_g3();
    logic [15:0] v;
    sleep_state = 3'd1; pwr_good_a = 1'b0; step(3);
    rd(0, v); check("R2 set in S1", v, 16'h0001);
    sleep_state = 3'd7; step(1);
    rd(0, v); check("R3 G3 clears", v, 16'h0000);
    pwr_good_a = 1'b1; step(4);
    sleep_state = 3'd0;
  endtask

  task automatic t_cpu_race();
    logic [15:0] v;
    vreg_good_a = 1'b0;
    step(2);
    wr(0, 16'h0002);
    rd(0, v); check("R12 set wins over clear", v, 16'h0002);
    wr(0, 16'h0002);
    rd(0, v); check("R4 write 1 clears", v, 16'h0000);
    step(6);
    rd(0, v); check("R12 no re-set while low", v, 16'h0000);
    vreg_good_a = 1'b1; step(4);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cfg_bits();
    t_batt();
    t_glitch();
    t_full(1'b0, 3'd0, 3'd0, 1'b1, 16'h0001, "R6 full en0");
    t_full(1'b1, 3'd3, 3'd5, 1'b0, 16'h0000, "R7 full en1 S5");
    t_full(1'b1, 3'd4, 3'd4, 1'b0, 16'h0000, "R7 full en1 S4");
    t_g3();
    t_cpu_race();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule